// File: doc/BRIEF.md
# Power-Down Sequencer

This block steps a supply supervisor into a low-power state and back out. It watches an active-low external sleep pin and an internal sleep request that other logic drives. A static configuration input chooses which of the two starts a power-down. When the internal request is chosen, the pin can only bring the device back up, and it does so by being high. The sequencer runs from a 250 kHz tick, so one cycle is 4 us. Every interval is counted in cycles of that tick.

Power-down passes through five states: ACTIVE, ENTERING, DOWN_HOLD, DOWN and EXITING. The device is usable only in ACTIVE, and `run_ok` is the enable that gates the rest of the device. The pin is synchronised through two flip-flops before it is used. The internal request is already in the clock domain and is used directly. All inputs and outputs are plain level signals, with no handshake.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset, `run_ok` is 1, `in_lowpower` is 0 and `io_supply_off` is 0.
- R2: With `cfg_int_src`=0, a low on `sleep_n` drives `run_ok` low 3 cycles after it is applied. Two of those cycles are the synchroniser and one is the state register.
- R3: After leaving ACTIVE, the block spends exactly ENTER_TICKS cycles (default 25) entering, and then `in_lowpower` rises.
- R4: `in_lowpower` stays high for at least HOLD_TICKS cycles (default 25), even when an exit is already requested.
- R5: An exit starts only while the synchronised `sleep_n` is high. `in_lowpower` falls when the exit starts. `run_ok` rises exactly EXIT_TICKS cycles later (default 75).
- R6: `io_supply_off` is high in exactly the cycles in which `in_lowpower` is high.
- R7: With `cfg_int_src`=1, a high on `int_sleep_req` starts entry on the next cycle, and a low `sleep_n` does not start entry.
- R8: With `cfg_int_src`=1, dropping `int_sleep_req` does not end power-down. Only `sleep_n` high does.
- R9: With `cfg_int_src`=0, `int_sleep_req` has no effect.
- R10: A request withdrawn during entry still completes the entry and the minimum hold before exiting.
- R11: A full cycle, from leaving ACTIVE to returning to it, lasts at least ENTER_TICKS+HOLD_TICKS+EXIT_TICKS cycles (500 us).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 250 kHz system tick |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_int_src | input | 1 | 1: internal request starts power-down; 0: pin starts it |
| sleep_n | input | 1 | External pin, low requests power-down, high requests run |
| int_sleep_req | input | 1 | Internal power-down request, active high |
| in_lowpower | output | 1 | High in the hold and down states |
| io_supply_off | output | 1 | Turns the I/O supply off while powered down |
| run_ok | output | 1 | High only in ACTIVE; enables the rest of the device |

## Verification
The sequence is exercised in five ways:
- A pin-driven cycle with the request held low measures each interval separately.
- A short pin pulse that ends during entry separates "entry completes and holds" from "entry aborts".
- With the pin selected, a raised internal request must leave the device running.
- With the internal source selected, a low pin alone must leave the device running.
- An internally started cycle, in which the request drops long before the pin rises, shows that only the pin ends power-down.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE   = 3'd0,
    ST_ENTERING = 3'd1,
    ST_HOLD     = 3'd2,
    ST_DOWN     = 3'd3,
    ST_EXITING  = 3'd4
  } pd_state_e;
endpackage

// File: rtl/pwrdn_sync2.sv
module pwrdn_sync2 #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end
  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrdn_timer.sv
module pwrdn_timer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign done = (cnt == '0);
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq
  import pwrdn_pkg::*;
#(
  parameter int ENTER_TICKS = 25,
  parameter int HOLD_TICKS  = 25,
  parameter int EXIT_TICKS  = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_int_src,
  input  logic sleep_n,
  input  logic int_sleep_req,
  output logic in_lowpower,
  output logic io_supply_off,
  output logic run_ok
);
  localparam int MAX_T = (EXIT_TICKS > ENTER_TICKS) ?
                         ((EXIT_TICKS > HOLD_TICKS) ? EXIT_TICKS : HOLD_TICKS) :
                         ((ENTER_TICKS > HOLD_TICKS) ? ENTER_TICKS : HOLD_TICKS);
  localparam int TW = $clog2(MAX_T + 1);
  localparam logic [TW-1:0] ENTER_LD = TW'(ENTER_TICKS - 1);
  localparam logic [TW-1:0] HOLD_LD  = TW'(HOLD_TICKS - 1);
  localparam logic [TW-1:0] EXIT_LD  = TW'(EXIT_TICKS - 1);

  logic pin_sync;
  logic enter_req;
  logic exit_req;
  logic tmr_load;
  logic [TW-1:0] tmr_val;
  logic tmr_done;
  pd_state_e state_q, state_d;

  pwrdn_sync2 #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sleep_n), .q(pin_sync)
  );

  pwrdn_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  assign enter_req = cfg_int_src ? int_sleep_req : !pin_sync;
  assign exit_req  = pin_sync;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = ENTER_LD;
    unique case (state_q)
      ST_ACTIVE: if (enter_req) begin
        state_d  = ST_ENTERING;
        tmr_load = 1'b1;
        tmr_val  = ENTER_LD;
      end
      ST_ENTERING: if (tmr_done) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = HOLD_LD;
      end
      ST_HOLD: if (tmr_done) state_d = ST_DOWN;
      ST_DOWN: if (exit_req) begin
        state_d  = ST_EXITING;
        tmr_load = 1'b1;
        tmr_val  = EXIT_LD;
      end
      ST_EXITING: if (tmr_done) state_d = ST_ACTIVE;
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ACTIVE;
    else        state_q <= state_d;
  end

  assign in_lowpower   = (state_q == ST_HOLD) || (state_q == ST_DOWN);
  assign io_supply_off = in_lowpower;
  assign run_ok        = (state_q == ST_ACTIVE);
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk
  import pwrdn_pkg::*;
#(
  parameter int ENTER_TICKS = 25,
  parameter int HOLD_TICKS  = 25,
  parameter int EXIT_TICKS  = 75
) (
  input logic      clk,
  input logic      rst_n,
  input logic      in_lowpower,
  input logic      io_supply_off,
  input logic      run_ok,
  input logic      enter_req,
  input logic      pin_s,
  input pd_state_e st
);
  logic [15:0] lp_cnt, en_cnt, ex_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_cnt <= '0; en_cnt <= '0; ex_cnt <= '0;
    end else begin
      lp_cnt <= in_lowpower ? ((lp_cnt == 16'hFFFF) ? lp_cnt : lp_cnt + 1'b1) : '0;
      en_cnt <= (st == ST_ENTERING) ? en_cnt + 1'b1 : '0;
      ex_cnt <= (st == ST_EXITING)  ? ex_cnt + 1'b1 : '0;
    end
  end

  a_r2_leave_only_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_ok) |-> $past(enter_req));
  a_r3_enter_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_lowpower) |-> (en_cnt == 16'(ENTER_TICKS)));
  a_r4_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_lowpower) |-> (lp_cnt >= 16'(HOLD_TICKS)));
  a_r5_exit_on_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_lowpower) |-> $past(pin_s));
  a_r5_exit_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_ok) |-> (ex_cnt == 16'(EXIT_TICKS)));
  a_r6_io_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_lowpower) |-> io_supply_off);
endmodule

bind pwrdn_seq pwrdn_seq_chk #(
  .ENTER_TICKS(ENTER_TICKS), .HOLD_TICKS(HOLD_TICKS), .EXIT_TICKS(EXIT_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_lowpower(in_lowpower), .io_supply_off(io_supply_off),
  .run_ok(run_ok), .enter_req(enter_req), .pin_s(pin_sync), .st(state_q)
);

// File: tb/tb_pwrdn_seq.sv
module tb_pwrdn_seq;
  localparam time CLK_PERIOD = 4000ns;
  localparam int ENTER_T = 25, HOLD_T = 25, EXIT_T = 75;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_int_src = 1'b0;
  logic sleep_n = 1'b1;
  logic int_sleep_req = 1'b0;
  logic in_lowpower, io_supply_off, run_ok;
  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_seq #(.ENTER_TICKS(ENTER_T), .HOLD_TICKS(HOLD_T), .EXIT_TICKS(EXIT_T)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_int_src(cfg_int_src), .sleep_n(sleep_n),
    .int_sleep_req(int_sleep_req), .in_lowpower(in_lowpower),
    .io_supply_off(io_supply_off), .run_ok(run_ok)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // count edges until run_ok or in_lowpower reaches val (which: 0=run_ok, 1=lowpower)
  task automatic wait_for(input int which, input logic val, output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      step(); n++;
      if ((which == 0 ? run_ok : in_lowpower) == val) return;
    end
  endtask

  task automatic t_reset();
    chk(run_ok, 1, "R1 run_ok");
    chk(in_lowpower, 0, "R1 in_lowpower");
    chk(io_supply_off, 0, "R1 io_supply_off");
  endtask

  task automatic t_ext_cycle();
    int n;
    cfg_int_src = 0; int_sleep_req = 0; sleep_n = 0;
    wait_for(0, 1'b0, n); chk(n, 3, "R2 latency to leave active");
    wait_for(1, 1'b1, n); chk(n, ENTER_T, "R3 enter interval");
    chk(io_supply_off, 1, "R6 io off while down");
    for (int i = 0; i < 40; i++) step();
    chk(in_lowpower, 1, "R5 stays down while pin low");
    chk(io_supply_off, 1, "R6 io off held");
    sleep_n = 1;
    wait_for(1, 1'b0, n); chk(n, 3, "R5 exit start latency");
    chk(io_supply_off, 0, "R6 io on after exit start");
    wait_for(0, 1'b1, n); chk(n, EXIT_T, "R5 exit interval");
  endtask

  task automatic t_early_release();
    int n = 0, lp_len = 0, total;
    cfg_int_src = 0; sleep_n = 0;
    for (int i = 0; i < 400; i++) begin
      step(); n++;
      if (n == 5) sleep_n = 1;
      if (in_lowpower) break;
    end
    chk(n, 3 + ENTER_T, "R10 withdrawn request still completes entry");
    while (in_lowpower && lp_len < 400) begin step(); lp_len++; end
    chk(lp_len, HOLD_T + 1, "R4 minimum hold honoured");
    total = n + lp_len;
    while (!run_ok && total < 600) begin step(); total++; end
    chk(total - 2, 2 + ENTER_T + HOLD_T + EXIT_T - 1 + 1, "R11 full cycle length");
    chk(int'(total - 3 >= ENTER_T + HOLD_T + EXIT_T), 1, "R11 at least 500 us");
  endtask

  task automatic t_req_ignored_ext();
    int low = 0;
    cfg_int_src = 0; sleep_n = 1; int_sleep_req = 1;
    for (int i = 0; i < 40; i++) begin step(); if (!run_ok) low++; end
    chk(low, 0, "R9 internal request ignored in pin mode");
    int_sleep_req = 0;
  endtask

  task automatic t_pin_ignored_int();
    int low = 0;
    cfg_int_src = 1; int_sleep_req = 0; sleep_n = 0;
    for (int i = 0; i < 40; i++) begin step(); if (!run_ok) low++; end
    chk(low, 0, "R7 low pin does not enter in internal mode");
  endtask

  task automatic t_int_cycle();
    int n;
    cfg_int_src = 1; sleep_n = 0; int_sleep_req = 1;
    wait_for(0, 1'b0, n); chk(n, 1, "R7 internal request entry latency");
    wait_for(1, 1'b1, n); chk(n, ENTER_T, "R3 enter interval internal");
    int_sleep_req = 0;
    for (int i = 0; i < 60; i++) step();
    chk(in_lowpower, 1, "R8 dropped request does not exit");
    sleep_n = 1;
    wait_for(1, 1'b0, n); chk(n, 3, "R8 pin high exits");
    wait_for(0, 1'b1, n); chk(n, EXIT_T, "R5 exit interval internal");
    for (int i = 0; i < 5; i++) step();
    chk(run_ok, 1, "R8 stays active after exit");
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    t_reset();
    t_ext_cycle();
    step();
    t_early_release();
    step();
    t_req_ignored_ext();
    t_pin_ignored_int();
    t_int_cycle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule